// File: doc/BRIEF.md
# Move-Instruction Control Sequencer

This block runs the control side of a processor that has a single operation: copy one memory word into another. Each instruction is one word. Its upper byte names the destination and its lower byte names the source. The sequencer steps through eight phases for every instruction:

- it advances the program counter;
- it fetches the instruction word at the new counter value;
- it splits that word into source and destination addresses;
- it reads the source word;
- it writes that word to the destination.

The sequencer keeps four registers: a program counter, a command register, an address register and an address-hold register. The command register holds the fetched instruction first and the moved data word after that.

The memory lives outside the block. Its read port is combinational, and the block samples read data at the clock edge that ends a read phase. The program counter also has an address in the memory map. A move whose destination is that address replaces the counter with the low byte of the moved word. The counter is incremented before every fetch, so software jumps to location X by writing X-1. A halt input stops the sequencer between clock edges so that its state can be inspected.

Top module: `mov_seq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the program counter output, the phase output and the memory address are all 0 and write enable is low. The first instruction is fetched from address 0x01.
- R2: The phase output counts 0,1,2,3,4,5,6,7 and wraps to 0, one step per clock edge while halt is low. The encoding is 0 increment, 1 fetch, 2 decode, 3 source read, 4 restore, 5 write, 6 clear, 7 idle.
- R3: The program counter rises by exactly 1, modulo 256, at the end of phase 0. It changes at no other time except under R8.
- R4: During phases 1 and 2 the memory address equals the incremented program counter. The word read during phase 1 is the instruction.
- R5: During phases 3 and 4 the memory address equals bits [7:0] of the instruction (the source).
- R6: During phases 5 and 6 the memory address equals bits [15:8] of the instruction (the destination). During phase 5 the write data is the word read from the source at the end of phase 3.
- R7: Write enable is high only during phase 5, for exactly one unhalted cycle per instruction.
- R8: A write to address 0x00 loads bits [7:0] of the write data into the program counter. The next fetch is then from that value plus 1, modulo 256.
- R9: The memory address is 0 during phases 7 and 0.
- R10: While halt is high, the phase and the program counter keep their values, no register loads, and write enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes sequencing while high |
| mem_rdata | input | 16 | Combinational read data for mem_addr |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Data to write |
| mem_we | output | 1 | Write strobe, applied at the clock edge |
| pc_out | output | 8 | Current program counter |
| phase_out | output | 3 | Current phase (encoding in R2) |

## Verification
The bench builds the block with its default 8-bit address, which gives a memory of 256 words, and it models all 256. With the full map present, random source and destination bytes can land anywhere, including the counter location 0x00. The counter can also wrap from 0xFF to 0x00 and fetch from there. A directed opening sequence forces a jump, the wrap, and a self-modifying jump before the random instructions run. Random halts fall in every phase.

// File: rtl/movseq_pkg.sv
package movseq_pkg;

    localparam int unsigned PH_W = 3;

    typedef enum logic [PH_W-1:0] {
        PH_INC     = 3'd0,
        PH_FETCH   = 3'd1,
        PH_DECODE  = 3'd2,
        PH_SRC     = 3'd3,
        PH_RESTORE = 3'd4,
        PH_WRITE   = 3'd5,
        PH_CLEAR   = 3'd6,
        PH_IDLE    = 3'd7
    } phase_e;

    // Per-phase control actions
    typedef struct packed {
        logic inc_pc;     // advance the program counter
        logic addr_pc;    // memory address taken from the counter
        logic ld_ar_pc;   // address register <- counter
        logic ld_cr;      // command register <- read data
        logic split;      // address <- low byte, hold <- high byte
        logic ld_ar_hold; // address register <- hold register
        logic we;         // memory write strobe
        logic clr_ar;     // address register <- 0
    } ctrl_t;

    localparam ctrl_t CTRL_NONE = '0;

    function automatic ctrl_t decode_phase(input phase_e ph);
        ctrl_t c;
        c = CTRL_NONE;
        unique case (ph)
            PH_INC:     c.inc_pc     = 1'b1;
            PH_FETCH: begin
                c.addr_pc  = 1'b1;
                c.ld_ar_pc = 1'b1;
                c.ld_cr    = 1'b1;
            end
            PH_DECODE:  c.split      = 1'b1;
            PH_SRC:     c.ld_cr      = 1'b1;
            PH_RESTORE: c.ld_ar_hold = 1'b1;
            PH_WRITE:   c.we         = 1'b1;
            PH_CLEAR:   c.clr_ar     = 1'b1;
            PH_IDLE:    c = CTRL_NONE;
            default:    c = CTRL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/movseq_phase_gen.sv
module movseq_phase_gen
    import movseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output phase_e phase
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_INC;
        end else if (adv) begin
            phase_q <= phase_e'(phase_q + 3'd1);
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/movseq_pc_unit.sv
module movseq_pc_unit #(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PC_LOC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_val,
    output logic [ADDR_W-1:0] pc
);

    logic [ADDR_W-1:0] pc_q;
    logic              hit;

    assign hit = wr_en && (wr_addr == PC_LOC);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (hit) begin
            pc_q <= wr_val;
        end else if (inc) begin
            pc_q <= pc_q + ADDR_W'(1);
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/movseq_regs.sv
module movseq_regs
    import movseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned WORD_W = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] ar,
    output logic [WORD_W-1:0] cr
);

    logic [ADDR_W-1:0] ar_q;
    logic [ADDR_W-1:0] ahr_q;
    logic [WORD_W-1:0] cr_q;

    // Address register: one source per phase
    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
        end else if (ctrl.ld_ar_pc) begin
            ar_q <= pc;
        end else if (ctrl.split) begin
            ar_q <= cr_q[ADDR_W-1:0];
        end else if (ctrl.ld_ar_hold) begin
            ar_q <= ahr_q;
        end else if (ctrl.clr_ar) begin
            ar_q <= '0;
        end
    end

    // Hold register keeps the destination across the source read
    always_ff @(posedge clk) begin
        if (rst) begin
            ahr_q <= '0;
        end else if (ctrl.split) begin
            ahr_q <= cr_q[WORD_W-1:ADDR_W];
        end
    end

    // Command register: instruction, then moved data
    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q <= '0;
        end else if (ctrl.ld_cr) begin
            cr_q <= rdata;
        end
    end

    assign ar = ar_q;
    assign cr = cr_q;

endmodule

// File: rtl/mov_seq_ctrl.sv
module mov_seq_ctrl
    import movseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PC_LOC = '0,
    localparam int unsigned WORD_W = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] pc_out,
    output logic [PH_W-1:0]   phase_out
);

    phase_e            phase;
    ctrl_t             ctrl_raw;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] ar;
    logic [WORD_W-1:0] cr;

    movseq_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .adv   (!halt),
        .phase (phase)
    );

    always_comb begin
        ctrl_raw = decode_phase(phase);
        ctrl     = halt ? CTRL_NONE : ctrl_raw;
    end

    movseq_pc_unit #(
        .ADDR_W (ADDR_W),
        .PC_LOC (PC_LOC)
    ) u_pc (
        .clk     (clk),
        .rst     (rst),
        .inc     (ctrl.inc_pc),
        .wr_en   (ctrl.we),
        .wr_addr (ar),
        .wr_val  (cr[ADDR_W-1:0]),
        .pc      (pc)
    );

    movseq_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .pc    (pc),
        .rdata (mem_rdata),
        .ar    (ar),
        .cr    (cr)
    );

    // During fetch the counter drives the address directly so the
    // instruction is read in the same phase the address register loads.
    assign mem_addr  = ctrl_raw.addr_pc ? pc : ar;
    assign mem_wdata = cr;
    assign mem_we    = ctrl.we;
    assign pc_out    = pc;
    assign phase_out = phase;

endmodule

// File: rtl/movseq_chk.sv
module movseq_chk #(
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned WORD_W = 2 * ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              halt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic [ADDR_W-1:0] pc_out,
    input logic [2:0]        phase_out
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(halt) |-> phase_out == 3'($past(phase_out) + 3'd1)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(halt) && $past(phase_out) == 3'd0 |-> pc_out == ADDR_W'($past(pc_out) + 1'b1)); // R3

    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
        phase_out == 3'd1 |-> mem_addr == pc_out); // R4

    AST_WE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> phase_out == 3'd5); // R7

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(mem_we) && $past(mem_addr) == '0 |-> pc_out == $past(mem_wdata[ADDR_W-1:0])); // R8

    AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        phase_out == 3'd0 || phase_out == 3'd7 |-> mem_addr == '0); // R9

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(halt) |-> $stable(phase_out) && $stable(pc_out)); // R10

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        halt |-> !mem_we); // R10

endmodule

bind mov_seq_ctrl movseq_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .pc_out    (pc_out),
    .phase_out (phase_out)
);

// File: tb/sim_mov_seq_ctrl.sv
module sim_mov_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;
    localparam int N_INSTR = 400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          halt = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [AW-1:0] pc_out;
    logic [2:0]    phase_out;

    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;

    logic [DW-1:0] mem     [DEPTH];
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] ref_pc;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mov_seq_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .halt      (halt),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .pc_out    (pc_out),
        .phase_out (phase_out)
    );

    // Memory model: combinational read, write at the clock edge
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input int k, input logic [AW-1:0] pcn,
                                               input logic [AW-1:0] s, input logic [AW-1:0] d);
        case (k)
            1, 2:    return pcn;
            3, 4:    return s;
            5, 6:    return d;
            default: return '0;
        endcase
    endfunction

    function automatic string addr_req(input int k);
        case (k)
            1, 2:    return "R4";
            3, 4:    return "R5";
            5, 6:    return "R6";
            default: return "R9";
        endcase
    endfunction

    // One instruction, with random halt cycles in between
    task automatic run_instr(input int halt_pct);
        logic [AW-1:0] pcn;
        logic [DW-1:0] ins;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [DW-1:0] dat;
        logic [2:0]    pre_ph;
        logic [AW-1:0] pre_pc;
        int            k;
        pcn = ref_pc + 1'b1;
        ins = ref_mem[pcn];
        src = ins[AW-1:0];
        dst = ins[DW-1:AW];
        dat = ref_mem[src];
        k = 0;
        while (k < 8) begin
            halt = ($urandom_range(0, 99) < halt_pct);
            #1;
            if (halt) begin
                pre_ph = phase_out;
                pre_pc = pc_out;
                chk("R10 we low in halt", int'(mem_we), 0);
                @(negedge clk);
                chk("R10 phase frozen", int'(phase_out), int'(pre_ph));
                chk("R10 pc frozen", int'(pc_out), int'(pre_pc));
            end else begin
                chk("R2 phase", int'(phase_out), k);
                chk(addr_req(k), int'(mem_addr), int'(exp_addr(k, pcn, src, dst)));
                chk("R7 we", int'(mem_we), (k == 5) ? 1 : 0);
                if (k == 1) chk("R3 pc incremented", int'(pc_out), int'(pcn));
                if (k == 5) chk("R6 write data", int'(mem_wdata), int'(dat));
                @(negedge clk);
                k++;
            end
        end
        halt = 1'b0;
        ref_mem[dst] = dat;
        ref_pc = (dst == '0) ? dat[AW-1:0] : pcn;
        if (dst == '0) chk("R8 pc loaded", int'(pc_out), int'(ref_pc));
        else           chk("R3 pc after move", int'(pc_out), int'(ref_pc));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = DW'($urandom);
        // Directed opening: jump, wrap past 0xFF, self-modifying jump
        ref_mem[8'h01] = 16'h0010;   // copy [0x10] to the counter
        ref_mem[8'h10] = 16'h00FD;   // jump target 0xFD -> next fetch 0xFE
        ref_mem[8'hFE] = 16'h1041;   // [0x41] -> [0x10]
        ref_mem[8'h41] = 16'h0030;
        ref_mem[8'hFF] = 16'h4243;   // plain move, then counter wraps to 0
        ref_mem[8'h00] = 16'h0010;   // fetched at address 0: jump to 0x30
        ref_pc = '0;

        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_addr = AW'(a);
            ld_data = ref_mem[a];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 pc in reset", int'(pc_out), 0);
        chk("R1 phase in reset", int'(phase_out), 0);
        chk("R1 addr in reset", int'(mem_addr), 0);
        chk("R1 we in reset", int'(mem_we), 0);

        rst = 1'b0;
        #1;
        chk("R1 phase after reset", int'(phase_out), 0);
        chk("R1 addr after reset", int'(mem_addr), 0);
        @(negedge clk);
        #1;
        chk("R1 first fetch address", int'(mem_addr), 1);
        @(negedge clk);
        // Restart cleanly so the bench is aligned to phase 0
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_pc = '0;
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = mem[a];

        // Directed instructions, no halts
        for (int i = 0; i < 4; i++) run_instr(0);
        // Random stream with halts
        for (int i = 0; i < N_INSTR; i++) run_instr(15);

        for (int a = 0; a < DEPTH; a++) chk("R6 memory contents", int'(mem[a]), int'(ref_mem[a]));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule